// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter

This block keeps the receive and transmit interrupt state for a pair of serial channels (channel A, index 0, and channel B, index 1). Each channel has a receive source and a transmit source. A source is raised by a one-cycle set pulse and dropped by a clear pulse or by a command from the register interface. Within a channel, only one source may be *in service* at a time. A source that arrives while the other one is in service stays pending. It enters service as soon as the other source is cleared.

The block reports state in three ways. The shared pending byte holds the in-service bits of both channels. Each channel has a vector byte that names the source currently in service. A single registered interrupt line is driven when either channel meets its enable conditions. The enable fields come from the channel configuration registers and are supplied as plain inputs: a master enable, a transmit enable, a two-bit receive mode, a break enable and the break status bit. The register decode that produces the pulses and commands is outside this block.

Top module: `irq_pend_arb`

## Requirements
- R1: The pending byte `pend_o` carries channel A receive-in-service at bit 5 and transmit-in-service at bit 4, and channel B receive-in-service at bit 2 and transmit-in-service at bit 1. Bits 7, 6, 3 and 0 are always 0.
- R2: A set pulse makes its source pending. A receive source enters service (pending-byte bit set, vector 4) only if transmit is not in service. A transmit source enters service (vector 0) only if receive is not in service. Sets are applied after clears, receive before transmit, so simultaneous receive and transmit sets on an idle channel give service to receive.
- R3: Clearing a source removes its pending and in-service state. If the other source of the channel is still pending, that source is promoted into service with its vector and pending-byte bit. Otherwise the vector becomes 6. When both clears of a channel occur in one cycle, receive is cleared first.
- R4: The reset-transmit command of a channel clears that channel's transmit source exactly as a transmit clear pulse does.
- R5: The reset-highest command clears receive if receive is in service, otherwise clears transmit if transmit is in service, and otherwise has no effect.
- R6: A channel requests an interrupt when its master enable is 1 and at least one of these holds:
  - the transmit enable is 1 and transmit is pending;
  - the receive mode is 2'b01 or 2'b10 and receive is pending;
  - the break enable and break status are both 1.
- R7: `irq_o` is the OR of both channels' requests. It is registered, so it reflects state and enable inputs one clock edge after they change.
- R8: A set and a clear of the same source in one cycle leave the source set.
- R9: After reset the pending byte is 0, both vectors are 6 and `irq_o` is 0.
- R10: Pulses and commands for one channel leave the other channel's vector and pending-byte bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set_i | input | 2 | Receive request set pulse per channel |
| rx_clr_i | input | 2 | Receive request clear pulse per channel |
| tx_set_i | input | 2 | Transmit request set pulse per channel |
| tx_clr_i | input | 2 | Transmit request clear pulse per channel |
| cmd_tx_rst_i | input | 2 | Reset-transmit-interrupt command per channel |
| cmd_hi_rst_i | input | 2 | Reset-highest-in-service command per channel |
| ie_master_i | input | 2 | Master interrupt enable per channel |
| ie_tx_i | input | 2 | Transmit interrupt enable per channel |
| rx_mode_i | input | 4 | Receive interrupt mode, two bits per channel (A in [1:0]) |
| brk_ie_i | input | 2 | Break interrupt enable per channel |
| brk_i | input | 2 | Break status per channel |
| pend_o | output | 8 | Shared pending byte |
| vec_a_o | output | 8 | Channel A vector |
| vec_b_o | output | 8 | Channel B vector |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives receive and transmit requests against each other so that one source is blocked behind the other. A design that let a blocked source enter service, or failed to promote it when the blocker cleared, would show the wrong pending bits or a stale vector. Same-cycle set-and-clear, double clears and reset-highest with nothing in service are also targeted. Swapping clear/set order would lose a request, and a wrong reset-highest priority would clear transmit while receive is still in service. Receive mode 2'b11 and the break path are exercised as well, since a loose mode decode or a missed break term shows as a wrong interrupt line.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int NCH    = 2;
    localparam int VEC_W  = 8;
    localparam int PEND_W = 8;
    localparam int MODE_W = 2;
    localparam int POS_W  = $clog2(PEND_W);

    localparam logic [VEC_W-1:0] VEC_RX   = VEC_W'(4);
    localparam logic [VEC_W-1:0] VEC_TX   = VEC_W'(0);
    localparam logic [VEC_W-1:0] VEC_IDLE = VEC_W'(6);

    localparam logic [NCH-1:0][POS_W-1:0] RX_POS = {POS_W'(2), POS_W'(5)};
    localparam logic [NCH-1:0][POS_W-1:0] TX_POS = {POS_W'(1), POS_W'(4)};

    typedef struct packed {
        logic             rx_pend;
        logic             tx_pend;
        logic             rx_svc;
        logic             tx_svc;
        logic [VEC_W-1:0] vec;
    } chan_st_t;
endpackage

// File: rtl/irq_chan_ctl.sv
module irq_chan_ctl
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_set_i,
    input  logic             rx_clr_i,
    input  logic             tx_set_i,
    input  logic             tx_clr_i,
    input  logic             cmd_tx_rst_i,
    input  logic             cmd_hi_rst_i,
    output logic             rx_pend_nx_o,
    output logic             tx_pend_nx_o,
    output logic             rx_svc_o,
    output logic             tx_svc_o,
    output logic [VEC_W-1:0] vec_o
);
    chan_st_t st_d, st_q;
    logic     kill_rx, kill_tx;

    always_comb begin
        st_d    = st_q;
        kill_rx = rx_clr_i | (cmd_hi_rst_i & st_q.rx_svc);
        kill_tx = tx_clr_i | cmd_tx_rst_i
                | (cmd_hi_rst_i & ~st_q.rx_svc & st_q.tx_svc);

        if (kill_rx) begin
            st_d.rx_pend = 1'b0;
            st_d.rx_svc  = 1'b0;
            if (st_d.tx_pend) begin
                st_d.tx_svc = 1'b1;
                st_d.vec    = VEC_TX;
            end else begin
                st_d.vec = VEC_IDLE;
            end
        end
        if (kill_tx) begin
            st_d.tx_pend = 1'b0;
            st_d.tx_svc  = 1'b0;
            if (st_d.rx_pend) begin
                st_d.rx_svc = 1'b1;
                st_d.vec    = VEC_RX;
            end else begin
                st_d.vec = VEC_IDLE;
            end
        end
        if (rx_set_i) begin
            st_d.rx_pend = 1'b1;
            if (!st_d.tx_svc) begin
                st_d.rx_svc = 1'b1;
                st_d.vec    = VEC_RX;
            end
        end
        if (tx_set_i) begin
            st_d.tx_pend = 1'b1;
            if (!st_d.rx_svc) begin
                st_d.tx_svc = 1'b1;
                st_d.vec    = VEC_TX;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rx_pend: 1'b0, tx_pend: 1'b0, rx_svc: 1'b0,
                      tx_svc: 1'b0, vec: VEC_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_pend_nx_o = st_d.rx_pend;
    assign tx_pend_nx_o = st_d.tx_pend;
    assign rx_svc_o     = st_q.rx_svc;
    assign tx_svc_o     = st_q.tx_svc;
    assign vec_o        = st_q.vec;

    AST_SVC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rx_svc && st_q.tx_svc)); // R2
    AST_RX_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_i && !st_q.rx_svc && !st_q.tx_svc) |=> (rx_svc_o && vec_o == VEC_RX)); // R2
    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr_i && !rx_set_i) |=> !rx_svc_o); // R3
    AST_VEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o == VEC_RX || vec_o == VEC_TX || vec_o == VEC_IDLE)); // R3
    AST_TXRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tx_rst_i && !tx_set_i) |=> !tx_svc_o); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_i && rx_clr_i) |=> st_q.rx_pend); // R8
endmodule

// File: rtl/irq_req_eval.sv
module irq_req_eval
    import irq_arb_pkg::*;
(
    input  logic              rx_pend_i,
    input  logic              tx_pend_i,
    input  logic              ie_master_i,
    input  logic              ie_tx_i,
    input  logic [MODE_W-1:0] rx_mode_i,
    input  logic              brk_ie_i,
    input  logic              brk_i,
    output logic              req_o
);
    logic rx_mode_on;

    always_comb begin
        rx_mode_on = (rx_mode_i == MODE_W'(1)) || (rx_mode_i == MODE_W'(2));
        req_o = ie_master_i & ((ie_tx_i & tx_pend_i)
                             | (rx_mode_on & rx_pend_i)
                             | (brk_ie_i & brk_i));
    end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
    import irq_arb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             rx_set_i,
    input  logic [NCH-1:0]             rx_clr_i,
    input  logic [NCH-1:0]             tx_set_i,
    input  logic [NCH-1:0]             tx_clr_i,
    input  logic [NCH-1:0]             cmd_tx_rst_i,
    input  logic [NCH-1:0]             cmd_hi_rst_i,
    input  logic [NCH-1:0]             ie_master_i,
    input  logic [NCH-1:0]             ie_tx_i,
    input  logic [NCH-1:0][MODE_W-1:0] rx_mode_i,
    input  logic [NCH-1:0]             brk_ie_i,
    input  logic [NCH-1:0]             brk_i,
    output logic [PEND_W-1:0]          pend_o,
    output logic [VEC_W-1:0]           vec_a_o,
    output logic [VEC_W-1:0]           vec_b_o,
    output logic                       irq_o
);
    logic [NCH-1:0]            rx_pend_nx, tx_pend_nx, rx_svc, tx_svc, req;
    logic [NCH-1:0][VEC_W-1:0] vec;
    logic                      irq_d, irq_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        irq_chan_ctl u_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .rx_set_i     (rx_set_i[c]),
            .rx_clr_i     (rx_clr_i[c]),
            .tx_set_i     (tx_set_i[c]),
            .tx_clr_i     (tx_clr_i[c]),
            .cmd_tx_rst_i (cmd_tx_rst_i[c]),
            .cmd_hi_rst_i (cmd_hi_rst_i[c]),
            .rx_pend_nx_o (rx_pend_nx[c]),
            .tx_pend_nx_o (tx_pend_nx[c]),
            .rx_svc_o     (rx_svc[c]),
            .tx_svc_o     (tx_svc[c]),
            .vec_o        (vec[c])
        );
        irq_req_eval u_req (
            .rx_pend_i   (rx_pend_nx[c]),
            .tx_pend_i   (tx_pend_nx[c]),
            .ie_master_i (ie_master_i[c]),
            .ie_tx_i     (ie_tx_i[c]),
            .rx_mode_i   (rx_mode_i[c]),
            .brk_ie_i    (brk_ie_i[c]),
            .brk_i       (brk_i[c]),
            .req_o       (req[c])
        );
    end

    always_comb begin
        irq_d  = |req;
        pend_o = '0;
        for (int c = 0; c < NCH; c++) begin
            pend_o[RX_POS[c]] = rx_svc[c];
            pend_o[TX_POS[c]] = tx_svc[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o   = irq_q;
    assign vec_a_o = vec[0];
    assign vec_b_o = vec[1];

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_master_i == '0) |=> !irq_o); // R6
    AST_IRQ_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_master_i[0] && brk_ie_i[0] && brk_i[0]) |=> irq_o); // R7
    AST_PEND_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & 8'hC9) == 8'h00); // R1
endmodule

// File: tb/sim_irq_pend_arb.sv
module sim_irq_pend_arb;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
    logic [1:0]       cmd_tx = '0, cmd_hi = '0;
    logic [1:0]       ie_m = '0, ie_t = '0, brk_ie = '0, brk = '0;
    logic [1:0][1:0]  rmode = '0;
    logic [7:0]       pend, vec_a, vec_b;
    logic             irq;

    int checks = 0, errors = 0;
    int m_rp[2], m_tp[2], m_rs[2], m_ts[2], m_vec[2];
    bit m_irq;

    always #4 clk = ~clk;

    irq_pend_arb u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_set_i(rx_set), .rx_clr_i(rx_clr), .tx_set_i(tx_set), .tx_clr_i(tx_clr),
        .cmd_tx_rst_i(cmd_tx), .cmd_hi_rst_i(cmd_hi),
        .ie_master_i(ie_m), .ie_tx_i(ie_t), .rx_mode_i(rmode),
        .brk_ie_i(brk_ie), .brk_i(brk),
        .pend_o(pend), .vec_a_o(vec_a), .vec_b_o(vec_b), .irq_o(irq)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_rp[c] = 0; m_tp[c] = 0; m_rs[c] = 0; m_ts[c] = 0; m_vec[c] = 6;
        end
        m_irq = 0;
    endtask

    task automatic model_tick();
        bit any = 0;
        for (int c = 0; c < 2; c++) begin
            bit kr = rx_clr[c] || (cmd_hi[c] && m_rs[c] == 1);
            bit kt = tx_clr[c] || cmd_tx[c] || (cmd_hi[c] && m_rs[c] == 0 && m_ts[c] == 1);
            if (kr) begin
                m_rp[c] = 0; m_rs[c] = 0;
                if (m_tp[c] == 1) begin m_ts[c] = 1; m_vec[c] = 0; end
                else m_vec[c] = 6;
            end
            if (kt) begin
                m_tp[c] = 0; m_ts[c] = 0;
                if (m_rp[c] == 1) begin m_rs[c] = 1; m_vec[c] = 4; end
                else m_vec[c] = 6;
            end
            if (rx_set[c]) begin
                m_rp[c] = 1;
                if (m_ts[c] == 0) begin m_rs[c] = 1; m_vec[c] = 4; end
            end
            if (tx_set[c]) begin
                m_tp[c] = 1;
                if (m_rs[c] == 0) begin m_ts[c] = 1; m_vec[c] = 0; end
            end
            if (ie_m[c] && ((ie_t[c] && m_tp[c] == 1) ||
                ((rmode[c] == 2'b01 || rmode[c] == 2'b10) && m_rp[c] == 1) ||
                (brk_ie[c] && brk[c])))
                any = 1;
        end
        m_irq = any;
    endtask

    function automatic int exp_pend();
        return (m_rs[0] << 5) | (m_ts[0] << 4) | (m_rs[1] << 2) | (m_ts[1] << 1);
    endfunction

    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("R1 pending byte", pend, exp_pend());
        chk("R3 vector A", vec_a, m_vec[0]);
        chk("R10 vector B", vec_b, m_vec[1]);
        chk("R7 irq", irq, m_irq);
    endtask

    task automatic quiet();
        rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0; cmd_tx = '0; cmd_hi = '0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset pend", pend, 0);
        chk("R9 reset vec A", vec_a, 6);
        chk("R9 reset vec B", vec_b, 6);
        chk("R9 reset irq", irq, 0);

        ie_m = 2'b11; ie_t = 2'b11; rmode = {2'b10, 2'b01};
        rx_set[0] = 1; step(); quiet();
        chk("R2 A rx enters", pend, 8'h20); chk("R2 A rx vec", vec_a, 4);
        chk("R6 A rx mode 01 irq", irq, 1);
        tx_set[0] = 1; step(); quiet();
        chk("R2 A tx blocked", pend, 8'h20); chk("R2 A vec kept", vec_a, 4);
        cmd_hi[0] = 1; step(); quiet();
        chk("R5 hi clears rx / R3 promote tx", pend, 8'h10); chk("R3 vec tx", vec_a, 0);
        cmd_tx[0] = 1; step(); quiet();
        chk("R4 tx reset", pend, 0); chk("R4 vec idle", vec_a, 6);
        cmd_hi[0] = 1; step(); quiet();
        chk("R5 hi with nothing", pend, 0);
        rx_set[1] = 1; step(); quiet();
        chk("R1 B rx bit2", pend, 8'h04); chk("R10 A untouched", vec_a, 6);
        tx_set[1] = 1; step(); quiet();
        rx_clr[1] = 1; step(); quiet();
        chk("R3 B promote tx", pend, 8'h02); chk("R3 B vec", vec_b, 0);
        tx_set[1] = 1; tx_clr[1] = 1; step(); quiet();
        chk("R8 set wins", pend, 8'h02);
        tx_clr[1] = 1; step(); quiet();
        rx_set = 2'b01; tx_set = 2'b01; step(); quiet();
        chk("R2 simultaneous rx first", pend, 8'h20);
        rx_clr[0] = 1; tx_clr[0] = 1; step(); quiet();
        chk("R3 double clear", vec_a, 6);
        ie_t = 2'b00; rmode = {2'b11, 2'b11}; rx_set[0] = 1; step(); quiet();
        chk("R6 mode 11 no irq", irq, 0);
        brk_ie[0] = 1; brk[0] = 1; step();
        chk("R6 break irq", irq, 1);
        brk = '0; ie_m = 2'b00; step();
        chk("R6 master off", irq, 0);

        for (int i = 0; i < 3000; i++) begin
            rx_set = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            rx_clr = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            tx_set = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            tx_clr = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            cmd_tx = 2'($urandom_range(0, 3) & $urandom_range(0, 3) & $urandom_range(0, 3));
            cmd_hi = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            if (i % 16 == 0) begin
                ie_m = 2'($urandom_range(0, 3)); ie_t = 2'($urandom_range(0, 3));
                rmode = 4'($urandom_range(0, 15));
                brk_ie = 2'($urandom_range(0, 3)); brk = 2'($urandom_range(0, 3));
            end
            step();
        end
        quiet();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule